// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Violation Flag

This block is the digital receive path of one line channel. It takes recovered positive and negative pulse indications, one symbol per recovered clock cycle, and returns the original data stream. It removes the zero substitution codes used on the line: three-zero codes at DS3/STS-1 rates and four-zero codes at E3 rate. It also flags line code violations that are not part of a legal substitution code. With decoding turned off, the input is treated as plain alternate-mark-inversion.

The decoded result leaves the block either as separate positive/negative rails or as one binary stream. Both data outputs can be silenced while an external loss-of-signal flag is high. The output clock can be inverted, which moves the data transitions onto its falling edge.

The block looks at the newest symbol and the three cleaned symbols before it. It keeps the polarity of the most recent single-rail pulse. A pulse with the same polarity as that pulse is a violation candidate. If it completes a legal code, the code is erased; otherwise it is flagged and passed through.

Top module: `zsub_rx_decoder`

## Requirements
- R1: While reset is low, and after it is released with all inputs idle, `data_p_o`, `data_n_o` and `lcv_o` are 0.
- R2: The latency is fixed. A symbol sampled at rising edge t appears on the outputs after rising edge t+4. With `dec_en_i`=0, both rails pass through unchanged.
- R3: With `dec_en_i`=1 and `hdb3_sel_i`=0, a same-polarity pulse V that follows two empty slots (pattern 00V) is output as a zero.
- R4: With `dec_en_i`=1 and `hdb3_sel_i`=0, the pattern B0V is output as three zeros. Here B is a pulse in the slot two before V, with V's polarity.
- R5: With `dec_en_i`=1 and `hdb3_sel_i`=1, the patterns 000V and B00V are output as zeros. B00V means B three slots before V, with V's polarity. The pattern B0V is not legal in this mode and is flagged.
- R6: A same-polarity pulse that completes no legal pattern raises `lcv_o` for exactly that bit period, aligned with its own data bit. That bit is output as a pulse; `lcv_o` is 0 on every other bit.
- R7: A symbol with both rails high is flagged on `lcv_o` and passed through on both rails. It does not change the polarity history.
- R8: While `mute_en_i`=1 and `los_i`=1 (sampled at the output edge), both data outputs are 0. `lcv_o` is not muted. With either of the two low, data is not muted.
- R9: With `single_rail_i`=1, `data_p_o` carries the OR of the cleaned rails and `data_n_o` is 0.
- R10: With `dec_en_i`=0, no pattern is removed. 00V is output as received, with the V bit flagged.
- R11: `clk_o` equals `clk` when `clk_inv_i`=0 and its inverse when `clk_inv_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | recovered bit clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_p_i | input | 1 | positive pulse seen in this bit |
| rx_n_i | input | 1 | negative pulse seen in this bit |
| dec_en_i | input | 1 | 1 = remove substitution codes, 0 = plain AMI |
| hdb3_sel_i | input | 1 | 1 = four-zero codes (E3), 0 = three-zero codes |
| single_rail_i | input | 1 | 1 = binary stream on data_p_o |
| mute_en_i | input | 1 | enable data muting on loss of signal |
| los_i | input | 1 | loss-of-signal flag from the analog front end |
| clk_inv_i | input | 1 | invert the output clock |
| data_p_o | output | 1 | positive rail, or binary data in single-rail mode |
| data_n_o | output | 1 | negative rail, 0 in single-rail mode |
| lcv_o | output | 1 | line code violation, one bit wide |
| clk_o | output | 1 | output clock, optionally inverted |

## Verification
The same input pattern is sent under different settings to show what each setting changes. The pattern `+00+` is decoded under the three-zero code (one surviving mark), under the four-zero code (everything erased as B00V) and with decoding off (passed through and flagged). The pattern `+0+` is erased under the three-zero code but flagged under the four-zero code. Back-to-back same-polarity marks and a both-rails symbol check that the flag lands on the offending bit and nowhere else. Three runs compare muted, unmuted and single-rail output, and another compares the output clock with and without inversion.

// File: rtl/zsub_rx_pkg.sv
package zsub_rx_pkg;
  // symbol carried through the window: positive, negative, violation flag
  typedef struct packed {
    logic p;
    logic n;
    logic v;
  } sym_t;

  localparam int WIN_STAGES = 3;               // cleaned history stages
  localparam int LATENCY    = WIN_STAGES + 1;  // capture + history + output
  localparam sym_t SYM_ZERO = '{p: 1'b0, n: 1'b0, v: 1'b0};
endpackage

// File: rtl/zsub_pol_track.sv
module zsub_pol_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_p,
  input  logic sym_n,
  output logic pol_neg,
  output logic pol_vld
);
  logic pol_neg_d;
  logic pol_vld_d;

  always_comb begin
    pol_neg_d = pol_neg;
    pol_vld_d = pol_vld;
    if (sym_p ^ sym_n) begin
      pol_neg_d = sym_n;
      pol_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_neg <= 1'b0;
      pol_vld <= 1'b0;
    end else begin
      pol_neg <= pol_neg_d;
      pol_vld <= pol_vld_d;
    end
  end
endmodule

// File: rtl/zsub_viol_class.sv
module zsub_viol_class
  import zsub_rx_pkg::*;
(
  input  sym_t cur,
  input  sym_t h1,
  input  sym_t h2,
  input  sym_t h3,
  input  logic pol_neg,
  input  logic pol_vld,
  input  logic dec_en,
  input  logic hdb3_sel,
  output logic clr_cur,
  output logic clr_h2,
  output logic clr_h3,
  output logic viol
);
  logic m1, m2, m3;
  logic both, single, same;
  logic b3_00v, b3_b0v, hd_000v, hd_b00v;
  logic legal;

  always_comb begin
    m1      = h1.p | h1.n;
    m2      = h2.p | h2.n;
    m3      = h3.p | h3.n;
    both    = cur.p & cur.n;
    single  = cur.p ^ cur.n;
    same    = single & pol_vld & (cur.n == pol_neg);
    b3_00v  = !m1 && !m2;
    b3_b0v  = !m1 && (h2.p ^ h2.n) && (h2.n == cur.n);
    hd_000v = !m1 && !m2 && !m3;
    hd_b00v = !m1 && !m2 && (h3.p ^ h3.n) && (h3.n == cur.n);
    legal   = dec_en && same &&
              (hdb3_sel ? (hd_000v || hd_b00v) : (b3_00v || b3_b0v));
    clr_cur = legal;
    clr_h2  = legal && !hdb3_sel && b3_b0v;
    clr_h3  = legal && hdb3_sel && hd_b00v;
    viol    = both || (same && !legal);
  end
endmodule

// File: rtl/zsub_win_pipe.sv
module zsub_win_pipe
  import zsub_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_p,
  input  logic rx_n,
  input  logic clr_cur,
  input  logic clr_h2,
  input  logic viol,
  output sym_t cur,
  output sym_t hist [1:WIN_STAGES]
);
  sym_t cur_d;
  sym_t hist_d [1:WIN_STAGES];

  always_comb begin
    cur_d   = '{p: rx_p, n: rx_n, v: 1'b0};
    hist_d[1] = clr_cur ? SYM_ZERO : '{p: cur.p, n: cur.n, v: viol};
  end

  // later stages shift; stage 3 takes stage 2 cleared when a B0V B sits there
  for (genvar k = 2; k <= WIN_STAGES; k++) begin : g_stage
    if (k == 3) begin : g_clr
      always_comb hist_d[k] = clr_h2 ? SYM_ZERO : hist[k-1];
    end else begin : g_pass
      always_comb hist_d[k] = hist[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= SYM_ZERO;
      for (int k = 1; k <= WIN_STAGES; k++) hist[k] <= SYM_ZERO;
    end else begin
      cur <= cur_d;
      for (int k = 1; k <= WIN_STAGES; k++) hist[k] <= hist_d[k];
    end
  end
endmodule

// File: rtl/zsub_out_stage.sv
module zsub_out_stage
  import zsub_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_t last,
  input  logic clr_last,
  input  logic single_rail,
  input  logic mute,
  output logic data_p,
  output logic data_n,
  output logic lcv
);
  sym_t sel;
  logic p_d, n_d, l_d;

  always_comb begin
    sel = clr_last ? SYM_ZERO : last;
    l_d = sel.v;
    if (single_rail) begin
      p_d = sel.p | sel.n;
      n_d = 1'b0;
    end else begin
      p_d = sel.p;
      n_d = sel.n;
    end
    if (mute) begin
      p_d = 1'b0;
      n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_p <= 1'b0;
      data_n <= 1'b0;
      lcv    <= 1'b0;
    end else begin
      data_p <= p_d;
      data_n <= n_d;
      lcv    <= l_d;
    end
  end
endmodule

// File: rtl/zsub_rx_decoder.sv
module zsub_rx_decoder
  import zsub_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_p_i,
  input  logic rx_n_i,
  input  logic dec_en_i,
  input  logic hdb3_sel_i,
  input  logic single_rail_i,
  input  logic mute_en_i,
  input  logic los_i,
  input  logic clk_inv_i,
  output logic data_p_o,
  output logic data_n_o,
  output logic lcv_o,
  output logic clk_o
);
  sym_t cur;
  sym_t hist [1:WIN_STAGES];
  logic pol_neg, pol_vld;
  logic clr_cur, clr_h2, clr_h3, viol;

  zsub_win_pipe i_pipe (
    .clk(clk), .rst_n(rst_n), .rx_p(rx_p_i), .rx_n(rx_n_i),
    .clr_cur(clr_cur), .clr_h2(clr_h2), .viol(viol),
    .cur(cur), .hist(hist)
  );

  zsub_pol_track i_pol (
    .clk(clk), .rst_n(rst_n), .sym_p(cur.p), .sym_n(cur.n),
    .pol_neg(pol_neg), .pol_vld(pol_vld)
  );

  zsub_viol_class i_class (
    .cur(cur), .h1(hist[1]), .h2(hist[2]), .h3(hist[3]),
    .pol_neg(pol_neg), .pol_vld(pol_vld),
    .dec_en(dec_en_i), .hdb3_sel(hdb3_sel_i),
    .clr_cur(clr_cur), .clr_h2(clr_h2), .clr_h3(clr_h3), .viol(viol)
  );

  zsub_out_stage i_out (
    .clk(clk), .rst_n(rst_n), .last(hist[WIN_STAGES]), .clr_last(clr_h3),
    .single_rail(single_rail_i), .mute(mute_en_i & los_i),
    .data_p(data_p_o), .data_n(data_n_o), .lcv(lcv_o)
  );

  assign clk_o = clk ^ clk_inv_i;
endmodule

// File: rtl/zsub_rx_decoder_chk.sv
module zsub_rx_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_p_i,
  input logic rx_n_i,
  input logic dec_en_i,
  input logic hdb3_sel_i,
  input logic single_rail_i,
  input logic mute_en_i,
  input logic los_i,
  input logic clk_inv_i,
  input logic data_p_o,
  input logic data_n_o,
  input logic lcv_o,
  input logic clk_o
);
  logic [2:0] ami_run;

  // consecutive edges with plain pass-through settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ami_run <= 3'd0;
    else if (!dec_en_i && !single_rail_i && !(mute_en_i && los_i))
      ami_run <= (ami_run == 3'd7) ? ami_run : ami_run + 3'd1;
    else ami_run <= 3'd0;
  end

  AST_AMI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ami_run >= 3'd5) |-> (data_p_o == $past(rx_p_i, 5) && data_n_o == $past(rx_n_i, 5))); // R2

  AST_LCV_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (lcv_o && !$past(mute_en_i && los_i)) |-> (data_p_o || data_n_o)); // R6

  AST_MUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en_i && los_i) |=> (!data_p_o && !data_n_o)); // R8

  AST_SINGLE_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    single_rail_i |=> !data_n_o); // R9
endmodule

bind zsub_rx_decoder zsub_rx_decoder_chk i_chk (.*);

// File: tb/test_zsub_rx_decoder.sv
module test_zsub_rx_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_p, rx_n, dec_en, hdb3_sel, single_rail, mute_en, los, clk_inv;
  logic data_p, data_n, lcv, clk_o;

  typedef struct {
    int    due;
    logic  p;
    logic  n;
    logic  l;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  zsub_rx_decoder i_zsub_rx_decoder (
    .clk(clk), .rst_n(rst_n), .rx_p_i(rx_p), .rx_n_i(rx_n),
    .dec_en_i(dec_en), .hdb3_sel_i(hdb3_sel), .single_rail_i(single_rail),
    .mute_en_i(mute_en), .los_i(los), .clk_inv_i(clk_inv),
    .data_p_o(data_p), .data_n_o(data_n), .lcv_o(lcv), .clk_o(clk_o)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got p/n/lcv=%b expected %b at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  // monitor: outputs after each edge, compared to queued expectations
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].due == cyc) begin
        check(q[0].req, {data_p, data_n, lcv}, {q[0].p, q[0].n, q[0].l});
        void'(q.pop_front());
      end
    end
  end

  // driver: one symbol per cycle, expectation due LATENCY edges after capture
  task automatic sym(input logic p, input logic n, input logic ep, input logic en,
                     input logic el, input string req);
    exp_t e;
    @(negedge clk);
    rx_p = p;
    rx_n = n;
    e.due = cyc + 5;
    e.p = ep; e.n = en; e.l = el; e.req = req;
    q.push_back(e);
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 6; i++) sym(0, 0, 0, 0, 0, req);
  endtask

  task automatic cfg(input logic de, input logic hd, input logic sr,
                     input logic me, input logic ls);
    @(negedge clk);
    dec_en = de; hdb3_sel = hd; single_rail = sr; mute_en = me; los = ls;
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_p = 0; rx_n = 0; dec_en = 0; hdb3_sel = 0; single_rail = 0;
    mute_en = 0; los = 0; clk_inv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {data_p, data_n, lcv}, 3'b000);
    rst_n = 1'b1;
    flush("R1");

    // R2 / R6: AMI pass-through, back-to-back negative marks
    cfg(0, 0, 0, 0, 0);
    sym(1, 0, 1, 0, 0, "R2");
    sym(0, 1, 0, 1, 0, "R2");
    sym(0, 1, 0, 1, 1, "R6");
    sym(1, 0, 1, 0, 0, "R6");
    sym(0, 0, 0, 0, 0, "R2");
    flush("R2");
    // R7: both rails in one bit; history stays positive
    sym(1, 1, 1, 1, 1, "R7");
    sym(0, 1, 0, 1, 0, "R7");
    flush("R7");
    // R10: decoding off, 00V passes and is flagged
    sym(1, 0, 1, 0, 0, "R10");
    sym(0, 0, 0, 0, 0, "R10");
    sym(0, 0, 0, 0, 0, "R10");
    sym(1, 0, 1, 0, 1, "R10");
    flush("R10");

    // R3: three-zero code 00V
    cfg(1, 0, 0, 0, 0);
    sym(0, 1, 0, 1, 0, "R3");
    sym(0, 0, 0, 0, 0, "R3");
    sym(0, 0, 0, 0, 0, "R3");
    sym(0, 1, 0, 0, 0, "R3");
    flush("R3");
    // R4: B0V
    sym(1, 0, 0, 0, 0, "R4");
    sym(0, 0, 0, 0, 0, "R4");
    sym(1, 0, 0, 0, 0, "R4");
    sym(0, 1, 0, 1, 0, "R4");
    flush("R4");

    // R5: four-zero code, B00V then 000V
    cfg(1, 1, 0, 0, 0);
    sym(1, 0, 0, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(1, 0, 0, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(1, 0, 0, 0, 0, "R5");
    sym(0, 1, 0, 1, 0, "R5");
    flush("R5");
    // R5: B0V is illegal here and is flagged
    sym(1, 0, 1, 0, 0, "R5");
    sym(0, 0, 0, 0, 0, "R5");
    sym(1, 0, 1, 0, 1, "R5");
    flush("R5");

    // R9: single rail, three-zero code
    cfg(1, 0, 1, 0, 0);
    sym(0, 1, 1, 0, 0, "R9");
    sym(0, 0, 0, 0, 0, "R9");
    sym(0, 0, 0, 0, 0, "R9");
    sym(0, 1, 0, 0, 0, "R9");
    sym(1, 0, 1, 0, 0, "R9");
    sym(1, 0, 1, 0, 1, "R9");
    flush("R9");

    // R8: muting
    cfg(1, 0, 0, 1, 1);
    sym(0, 1, 0, 0, 0, "R8");
    sym(1, 0, 0, 0, 0, "R8");
    sym(1, 0, 0, 0, 1, "R8");
    flush("R8");
    cfg(1, 0, 0, 1, 0);
    sym(0, 1, 0, 1, 0, "R8");
    flush("R8");
    cfg(1, 0, 0, 0, 1);
    sym(1, 0, 1, 0, 0, "R8");
    flush("R8");

    // R11: output clock polarity
    @(negedge clk); #1;
    check("R11", {clk_o, 2'b00}, 3'b000);
    @(posedge clk); #1;
    check("R11", {clk_o, 2'b00}, 3'b100);
    @(negedge clk); clk_inv = 1'b1; #1;
    check("R11", {clk_o, 2'b00}, 3'b100);
    @(posedge clk); #1;
    check("R11", {clk_o, 2'b00}, 3'b000);

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule